// File: doc/BRIEF.md
# Second-Order Gain Correction Datapath

This block repairs the residue of the first stage of a pipelined converter. The residue is digitized by the later stages. The block multiplies it by a gain factor of one plus a second-order error polynomial, `1 + g0 + g2*Y^2`. It then merges the corrected residue with the first-stage decision digit to form the calibrated output word. The two gain-error coefficients come from a separate estimator. They are sampled along with each input sample.

The quadratic term only needs coarse precision, so `Y^2` is formed from a copy of the residue that keeps only its top `TW` bits. This keeps the squaring multiplier narrow. The final product with the residue uses every bit of it. The datapath accepts one sample per clock. Results appear a fixed three clocks later, together with a matching valid flag. The corrected residue and the output word are also the taps that feed the estimator.

Top module: `gcal_corr_top`

## Requirements
- R1: `o_valid` equals `i_valid` delayed by exactly 3 clocks. Samples given on consecutive clocks give results on consecutive clocks, in order.
- R2: `i_y` is signed with 12 fraction bits. `i_g0` and `i_g2` are signed with 15 fraction bits. `o_ycal` is 15-bit signed with 12 fraction bits and equals floor(Y*(2^15 + g0 + floor(g2*S/2^12))/2^15). S is defined in R3. A zero residue always gives a zero `o_ycal`, and `|o_ycal|` never exceeds 3*2^12.
- R3: S is the square of the residue arithmetic-shifted right by 6 (the top 7 bits kept). A residue whose top 7 bits are all zero gets no quadratic correction.
- R4: The residue enters the final product at full width, so a residue of one LSB with zero gains gives `o_ycal` = 1.
- R5: The digit is coded on `i_dig` as 01 = +1, 00 = 0, 11 = -1. The unused code 10 acts as 0. `o_outcal` = floor((digit*2^12 + `o_ycal`)/2), with 12 fraction bits.
- R6: While reset is active `o_valid` is 0. Samples in flight when reset asserts never appear at the outputs.
- R7: On a clock where `o_valid` is 0, `o_ycal` and `o_outcal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_valid | input | 1 | Input sample qualifier |
| i_y | input | YW (13) | Digitized first-stage residue, signed |
| i_dig | input | 2 | First-stage decision digit code |
| i_g0 | input | GW (16) | Constant gain-error estimate, signed |
| i_g2 | input | GW (16) | Quadratic gain-error estimate, signed |
| o_valid | output | 1 | Output qualifier, 3 clocks after `i_valid` |
| o_ycal | output | YW+2 (15) | Corrected residue, also tapped by the estimator |
| o_outcal | output | YW+2 (15) | Calibrated output word, also tapped by the estimator |

## Verification
The properties assume that `i_valid` is low for the whole time reset is held. They also assume that the gain inputs are presented with the sample they belong to. Any 16-bit gain value is legal, because the range bound in R2 holds for the full coefficient range. Time-shifted comparisons are enabled only once three clocks have passed since the internal reset was released. For this reason the stimulus holds `i_valid` low across both reset phases. It then drives every residue, digit code and gain value, including the extremes of each.

// File: rtl/gcal_pkg.sv
package gcal_pkg;

  // Two-bit code for the first-stage decision digit.
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_RSV  = 2'b10,
    DIG_NEG  = 2'b11
  } dig_code_e;

  // Map a digit code to a signed value in {-1, 0, +1}; the unused code maps to zero.
  function automatic logic signed [1:0] decode_digit(input logic [1:0] code);
    logic signed [1:0] val;
    unique case (dig_code_e'(code))
      DIG_POS: val = 2'sb01;
      DIG_NEG: val = 2'sb11;
      default: val = 2'sb00;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/gcal_sq_stage.sv
// Stage 1: decode the digit, form the square of the truncated residue,
// and capture the sample with its gain estimates.
module gcal_sq_stage #(
  parameter int YW = 13,
  parameter int TW = 7,
  parameter int GW = 16,
  localparam int SH  = YW - TW,
  localparam int SQW = 2 * TW
) (
  input  logic                  clk,
  input  logic                  rst_q,
  input  logic                  in_valid,
  input  logic signed [YW-1:0]  in_y,
  input  logic [1:0]            in_dig,
  input  logic signed [GW-1:0]  in_g0,
  input  logic signed [GW-1:0]  in_g2,
  output logic                  s1_valid,
  output logic signed [YW-1:0]  s1_y,
  output logic signed [1:0]     s1_d,
  output logic signed [GW-1:0]  s1_g0,
  output logic signed [GW-1:0]  s1_g2,
  output logic signed [SQW-1:0] s1_sq
);

  logic signed [TW-1:0]  ytr;
  logic signed [SQW-1:0] sq_nxt;
  logic signed [1:0]     d_nxt;
  logic                  ld;

  // Keep the most significant TW bits by arithmetic shift.
  generate
    if (SH > 0) begin : g_trunc
      always_comb ytr = TW'(in_y >>> SH);
    end else begin : g_full
      always_comb ytr = in_y;
    end
  endgenerate

  always_comb begin
    sq_nxt = ytr * ytr;
    d_nxt  = gcal_pkg::decode_digit(in_dig);
    ld     = in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      s1_y  <= in_y;
      s1_d  <= d_nxt;
      s1_g0 <= in_g0;
      s1_g2 <= in_g2;
      s1_sq <= sq_nxt;
    end
  end

endmodule

// File: rtl/gcal_gain_stage.sv
// Stage 2: build the gain factor 1 + g0 + g2*Y^2 in GF-fraction format.
module gcal_gain_stage #(
  parameter int YW = 13,
  parameter int TW = 7,
  parameter int GW = 16,
  localparam int SQW = 2 * TW,
  localparam int SQF = 2 * TW - 2,
  localparam int GF  = GW - 1,
  localparam int GTW = GW + 2,
  localparam int MW  = GW + SQW
) (
  input  logic                  clk,
  input  logic                  rst_q,
  input  logic                  s1_valid,
  input  logic signed [YW-1:0]  s1_y,
  input  logic signed [1:0]     s1_d,
  input  logic signed [GW-1:0]  s1_g0,
  input  logic signed [GW-1:0]  s1_g2,
  input  logic signed [SQW-1:0] s1_sq,
  output logic                  s2_valid,
  output logic signed [YW-1:0]  s2_y,
  output logic signed [1:0]     s2_d,
  output logic signed [GTW-1:0] s2_gt
);

  localparam logic signed [GTW-1:0] UNITY = GTW'(1) <<< GF;

  logic signed [MW-1:0]  quad;
  logic signed [GTW-1:0] quad_s;
  logic signed [GTW-1:0] gt_nxt;
  logic                  ld;

  always_comb begin
    quad   = MW'(s1_g2) * MW'(s1_sq);
    quad_s = GTW'(quad >>> SQF);
    gt_nxt = UNITY + GTW'(s1_g0) + quad_s;
    ld     = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      s2_y  <= s1_y;
      s2_d  <= s1_d;
      s2_gt <= gt_nxt;
    end
  end

endmodule

// File: rtl/gcal_out_stage.sv
// Stage 3: full-precision product with the residue, then merge with the digit.
module gcal_out_stage #(
  parameter int YW = 13,
  parameter int GW = 16,
  localparam int GF  = GW - 1,
  localparam int GTW = GW + 2,
  localparam int PW  = YW + GTW,
  localparam int CW  = YW + 2,
  localparam int YF  = YW - 1
) (
  input  logic                  clk,
  input  logic                  rst_q,
  input  logic                  s2_valid,
  input  logic signed [YW-1:0]  s2_y,
  input  logic signed [1:0]     s2_d,
  input  logic signed [GTW-1:0] s2_gt,
  output logic                  o_valid,
  output logic signed [CW-1:0]  o_ycal,
  output logic signed [CW-1:0]  o_outcal
);

  logic signed [PW-1:0] prod;
  logic signed [CW-1:0] ycal_nxt;
  logic signed [CW:0]   dterm;
  logic signed [CW:0]   sum;
  logic signed [CW-1:0] out_nxt;
  logic                 ld;

  always_comb begin
    prod     = PW'(s2_y) * PW'(s2_gt);
    ycal_nxt = CW'(prod >>> GF);
    dterm    = (CW+1)'(s2_d) <<< YF;
    sum      = dterm + (CW+1)'(ycal_nxt);
    out_nxt  = CW'(sum >>> 1);
    ld       = s2_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) o_valid <= 1'b0;
    else        o_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      o_ycal   <= ycal_nxt;
      o_outcal <= out_nxt;
    end
  end

endmodule

// File: rtl/gcal_corr_top.sv
module gcal_corr_top #(
  parameter int YW      = 13,
  parameter int TW      = 7,
  parameter int GW      = 16,
  parameter int RSYNC_N = 2,
  localparam int SQW = 2 * TW,
  localparam int GTW = GW + 2,
  localparam int CW  = YW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_valid,
  input  logic signed [YW-1:0] i_y,
  input  logic [1:0]           i_dig,
  input  logic signed [GW-1:0] i_g0,
  input  logic signed [GW-1:0] i_g2,
  output logic                 o_valid,
  output logic signed [CW-1:0] o_ycal,
  output logic signed [CW-1:0] o_outcal
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [RSYNC_N-1:0] rsync;
  logic               rst_q;

  generate
    if (RSYNC_N > 1) begin : g_rs_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= {rsync[RSYNC_N-2:0], 1'b1};
      end
    end else begin : g_rs_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= 1'b1;
      end
    end
  endgenerate

  assign rst_q = rsync[RSYNC_N-1];

  logic                  s1_valid;
  logic signed [YW-1:0]  s1_y;
  logic signed [1:0]     s1_d;
  logic signed [GW-1:0]  s1_g0;
  logic signed [GW-1:0]  s1_g2;
  logic signed [SQW-1:0] s1_sq;
  logic                  s2_valid;
  logic signed [YW-1:0]  s2_y;
  logic signed [1:0]     s2_d;
  logic signed [GTW-1:0] s2_gt;

  gcal_sq_stage #(.YW(YW), .TW(TW), .GW(GW)) u_sq (
    .clk(clk), .rst_q(rst_q),
    .in_valid(i_valid), .in_y(i_y), .in_dig(i_dig), .in_g0(i_g0), .in_g2(i_g2),
    .s1_valid(s1_valid), .s1_y(s1_y), .s1_d(s1_d),
    .s1_g0(s1_g0), .s1_g2(s1_g2), .s1_sq(s1_sq)
  );

  gcal_gain_stage #(.YW(YW), .TW(TW), .GW(GW)) u_gain (
    .clk(clk), .rst_q(rst_q),
    .s1_valid(s1_valid), .s1_y(s1_y), .s1_d(s1_d),
    .s1_g0(s1_g0), .s1_g2(s1_g2), .s1_sq(s1_sq),
    .s2_valid(s2_valid), .s2_y(s2_y), .s2_d(s2_d), .s2_gt(s2_gt)
  );

  gcal_out_stage #(.YW(YW), .GW(GW)) u_out (
    .clk(clk), .rst_q(rst_q),
    .s2_valid(s2_valid), .s2_y(s2_y), .s2_d(s2_d), .s2_gt(s2_gt),
    .o_valid(o_valid), .o_ycal(o_ycal), .o_outcal(o_outcal)
  );

endmodule

// File: rtl/gcal_corr_chk.sv
module gcal_corr_chk #(
  parameter int YW = 13,
  parameter int CW = YW + 2
) (
  input logic                 clk,
  input logic                 rst_q,
  input logic                 i_valid,
  input logic signed [YW-1:0] i_y,
  input logic [1:0]           i_dig,
  input logic                 o_valid,
  input logic signed [CW-1:0] o_ycal,
  input logic signed [CW-1:0] o_outcal
);

  localparam int LIM  = 3 <<< (YW - 1);
  localparam int HALF = 1 <<< (YW - 2);

  // Clocks since internal reset release, saturating at 3.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_q)
    (age == 2'd3) |-> (o_valid == $past(i_valid, 3)));

  a_r2_zero_res: assert property (@(posedge clk) disable iff (!rst_q)
    (age == 2'd3 && o_valid && $past(i_y, 3) == '0) |-> (o_ycal == '0));

  a_r2_range: assert property (@(posedge clk) disable iff (!rst_q)
    o_valid |-> ($signed(o_ycal) <= LIM && $signed(o_ycal) >= -LIM));

  a_r5_pos_digit: assert property (@(posedge clk) disable iff (!rst_q)
    (age == 2'd3 && o_valid && $past(i_y, 3) == '0 && $past(i_dig, 3) == 2'b01)
      |-> ($signed(o_outcal) == HALF));

  a_r6_reset_quiet: assert property (@(posedge clk)
    !rst_q |-> !o_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (age == 2'd3 && !o_valid) |-> ($stable(o_ycal) && $stable(o_outcal)));

endmodule

bind gcal_corr_top gcal_corr_chk #(.YW(YW), .CW(CW)) u_chk (
  .clk(clk), .rst_q(rst_q), .i_valid(i_valid), .i_y(i_y), .i_dig(i_dig),
  .o_valid(o_valid), .o_ycal(o_ycal), .o_outcal(o_outcal)
);

// File: tb/test_gcal_corr_top.sv
module test_gcal_corr_top;

  logic        clk;
  logic        rst_n;
  logic        i_valid;
  logic [12:0] i_y;
  logic [1:0]  i_dig;
  logic [15:0] i_g0;
  logic [15:0] i_g2;
  logic        o_valid;
  logic [14:0] o_ycal;
  logic [14:0] o_outcal;

  gcal_corr_top i_gcal_corr_top (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_y(i_y), .i_dig(i_dig),
    .i_g0(i_g0), .i_g2(i_g2), .o_valid(o_valid), .o_ycal(o_ycal), .o_outcal(o_outcal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected-result queue filled at launch, drained by the monitor.
  int exp_y [0:255];
  int exp_o [0:255];
  int launch [0:255];
  int wr = 0;
  int rd = 0;
  logic have_last = 1'b0;
  logic [14:0] last_y, last_o;

  typedef struct packed {
    logic [12:0] y;
    logic [1:0]  d;
    logic [15:0] g0;
    logic [15:0] g2;
    logic [14:0] ey;
    logic [14:0] eo;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{ 13'sd2048,  2'b01, 16'sd0,     16'sd0,     15'sd2048,  15'sd3072},
    '{ 13'sd0,     2'b11, 16'sd1000,  16'sd1000,  15'sd0,    -15'sd2048},
    '{ 13'sd1,     2'b00, 16'sd0,     16'sd0,     15'sd1,     15'sd0},    // R4
    '{-13'sd1,     2'b00, 16'sd0,     16'sd0,    -15'sd1,    -15'sd1},    // R4
    '{ 13'sd2048,  2'b00, 16'sd16384, 16'sd0,     15'sd3072,  15'sd1536},
    '{-13'sd2048,  2'b11, 16'sd16384, 16'sd0,    -15'sd3072, -15'sd3584},
    '{ 13'sd63,    2'b01, 16'sd0,     16'sd32767, 15'sd63,    15'sd2079}, // R3 top bits zero
    '{-13'sd4096,  2'b11, 16'sd0,     16'sd16384,-15'sd6144, -15'sd5120}, // R3 full-scale square
    '{ 13'sd2048,  2'b10, 16'sd0,     16'sd0,     15'sd2048,  15'sd1024}, // R5 unused code
    '{ 13'sd4095,  2'b01,-16'sd32768, 16'sd0,     15'sd0,     15'sd2048},
    '{ 13'sd2048,  2'b00, 16'sd0,     16'sd16384, 15'sd2304,  15'sd1152}, // R3
    '{-13'sd64,    2'b00, 16'sd0,     16'sd32767,-15'sd65,   -15'sd33}    // R3 floor
  };

  function automatic int ext15(input logic [14:0] v);
    return int'($signed(v));
  endfunction

  // Reference from the requirement formulas.
  function automatic void model(input int y, input logic [1:0] d, input int g0, input int g2,
                                output int ey, output int eo);
    longint yt, sq, q, gt, p;
    int dv;
    yt = longint'(y) >>> 6;
    sq = yt * yt;
    q  = (longint'(g2) * sq) >>> 12;
    gt = 32768 + longint'(g0) + q;
    p  = longint'(y) * gt;
    ey = int'(p >>> 15);
    dv = (d == 2'b01) ? 1 : ((d == 2'b11) ? -1 : 0);
    eo = (dv * 4096 + ey) >>> 1;
  endfunction

  task automatic idle();
    @(negedge clk);
    i_valid = 1'b0;
  endtask

  task automatic send(input logic [12:0] y, input logic [1:0] d, input logic [15:0] g0,
                      input logic [15:0] g2, input int ey, input int eo);
    @(negedge clk);
    i_valid = 1'b1; i_y = y; i_dig = d; i_g0 = g0; i_g2 = g2;
    exp_y[wr % 256] = ey; exp_o[wr % 256] = eo; launch[wr % 256] = cyc;
    wr++;
  endtask

  // Output monitor.
  always @(negedge clk) begin
    if (o_valid) begin
      checks++;
      if (rd == wr) begin
        errors++;
        $display("FAIL R1/R6: unexpected output, actual o_valid=1 expected 0");
      end else begin
        if (ext15(o_ycal) != exp_y[rd % 256]) begin
          errors++;
          $display("FAIL R2: o_ycal actual %0d expected %0d", ext15(o_ycal), exp_y[rd % 256]);
        end
        checks++;
        if (ext15(o_outcal) != exp_o[rd % 256]) begin
          errors++;
          $display("FAIL R5: o_outcal actual %0d expected %0d", ext15(o_outcal), exp_o[rd % 256]);
        end
        checks++;
        if (cyc - launch[rd % 256] != 3) begin
          errors++;
          $display("FAIL R1: latency actual %0d expected 3", cyc - launch[rd % 256]);
        end
        rd++;
      end
      last_y = o_ycal; last_o = o_outcal; have_last = 1'b1;
    end else if (have_last) begin
      checks++;
      if (o_ycal !== last_y || o_outcal !== last_o) begin
        errors++;
        $display("FAIL R7: held outputs actual %0d/%0d expected %0d/%0d",
                 ext15(o_ycal), ext15(o_outcal), ext15(last_y), ext15(last_o));
      end
    end
  end

  task automatic drain();
    repeat (5) idle();
    checks++;
    if (rd != wr) begin
      errors++;
      $display("FAIL R1: outputs seen actual %0d expected %0d", rd, wr);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ey, eo;
    logic [15:0] lfsr;
    rst_n = 1'b0; i_valid = 1'b0; i_y = '0; i_dig = '0; i_g0 = '0; i_g2 = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (o_valid !== 1'b0) begin
      errors++;
      $display("FAIL R6: o_valid in reset actual %b expected 0", o_valid);
    end
    rst_n = 1'b1;
    repeat (4) idle();

    // Table walk, back to back (R1 R2 R3 R4 R5).
    for (int k = 0; k < NV; k++)
      send(TBL[k].y, TBL[k].d, TBL[k].g0, TBL[k].g2, ext15(TBL[k].ey), ext15(TBL[k].eo));
    drain();

    // Idle gap: outputs must hold (R7), then gapped traffic.
    repeat (6) idle();
    for (int k = 0; k < 4; k++) begin
      model(k * 900 - 1500, 2'(k), 2000 * k, -3000 * k, ey, eo);
      send(13'(k * 900 - 1500), 2'(k), 16'(2000 * k), 16'(-3000 * k), ey, eo);
      idle();
    end
    drain();

    // Extremes of every input (R2 range, R3, R5).
    model(-4096, 2'b11, 32767, 32767, ey, eo);
    send(13'h1000, 2'b11, 16'h7fff, 16'h7fff, ey, eo);
    model(4095, 2'b01, 32767, 32767, ey, eo);
    send(13'h0fff, 2'b01, 16'h7fff, 16'h7fff, ey, eo);
    model(4095, 2'b11, -32768, -32768, ey, eo);
    send(13'h0fff, 2'b11, 16'h8000, 16'h8000, ey, eo);
    model(0, 2'b01, -32768, 32767, ey, eo);
    send(13'h0000, 2'b01, 16'h8000, 16'h7fff, ey, eo);

    // Pseudo-random burst against the reference (R2 R5).
    lfsr = 16'hace1;
    for (int k = 0; k < 40; k++) begin
      logic [12:0] ry;
      logic [15:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ry = lfsr[12:0];
      a  = lfsr ^ 16'h5a5a;
      b  = {lfsr[7:0], lfsr[15:8]};
      model(int'($signed(ry)), lfsr[1:0], int'($signed(a)), int'($signed(b)), ey, eo);
      send(ry, lfsr[1:0], a, b, ey, eo);
    end
    drain();

    // Reset with samples in flight: none may emerge (R6).
    send(13'sd1234, 2'b01, 16'sd0, 16'sd0, 0, 0);
    send(13'sd777, 2'b11, 16'sd0, 16'sd0, 0, 0);
    @(negedge clk);
    i_valid = 1'b0;
    rst_n = 1'b0;
    rd = wr;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (o_valid !== 1'b0) begin
        errors++;
        $display("FAIL R6: o_valid after reset actual %b expected 0", o_valid);
      end
    end
    rst_n = 1'b1;
    repeat (6) idle();
    model(-2048, 2'b01, 16384, 0, ey, eo);
    send(13'h1800, 2'b01, 16'sd16384, 16'sd0, ey, eo);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule